// File: doc/BRIEF.md
# Flash Status Register Write Guard

This block keeps the protection-related contents of a serial flash status register and decides, each time a status write instruction arrives, whether that write may change the register. It sits behind an instruction decoder that has already turned the serial stream into single-cycle strobes: an enable strobe, a status-write strobe with a 16-bit payload, a suspend strobe and a resume strobe. It also takes the level of the active-low write-protect pin and a single-cycle power-cycle event.

Write permission comes from a two-bit protection mode held in the register, from the pin level, and from the write enable latch. The modes are: software control, pin control, lock-down until the next power cycle, and permanent lock. Four security lock bits can only ever be set. A suspend flag is driven only by the suspend and resume strobes. The block shows the whole 16-bit register and gives a one-cycle accepted or rejected pulse after every status write attempt.

Top module: `flash_sr_guard`

## Requirements
- R1: While rst_n is low, sr_o reads 16'h0000 and wr_ok_o and wr_rej_o are 0; the reset acts without a clock edge.
- R2: An enable strobe sets the write enable latch, seen in sr_o bit 1 after the next edge. Any status write attempt, accepted or not, leaves bit 1 at 0.
- R3: With mode bits {bit 8, bit 7} = 00, a status write is accepted exactly when the latch was 1 before the attempt. The pin level has no effect.
- R4: With mode 01, a status write is rejected while wp_n_i is 0. While wp_n_i is 1 it is accepted exactly when the latch was 1.
- R5: With mode 10, every status write is rejected. A power cycle turns the mode into 00 and keeps every other stored bit.
- R6: With mode 11, every status write is rejected and the mode stays 11 across power cycles.
- R7: Bit 15 is set by the suspend strobe and cleared by the resume strobe, with resume winning when both arrive in one cycle. Status write data never changes it.
- R8: Bits 13..10 are lock bits. An accepted write ORs its data into them, so a set lock bit never returns to 0.
- R9: An accepted write loads bit 14 and bits 9..2 from the data. Bit 0 always reads 0, and data bits 1..0 are ignored.
- R10: The cycle after each status write attempt, exactly one of wr_ok_o (accepted) or wr_rej_o (rejected) is 1 for one cycle. A rejected write leaves bits 14..2 unchanged.
- R11: A power cycle clears bit 15 and the latch, and any other strobe in that same cycle is ignored.
- R12: When enable and status write strobes arrive together, the write is judged on the latch value from before that cycle, and the latch ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the as-shipped state |
| wren_i | input | 1 | Write enable instruction strobe |
| wrsr_i | input | 1 | Status write instruction strobe |
| wrsr_data_i | input | 16 | Status write payload |
| susp_i | input | 1 | Erase/program suspend instruction strobe |
| resume_i | input | 1 | Erase/program resume instruction strobe |
| wp_n_i | input | 1 | Active-low write-protect pin level |
| pwr_cycle_i | input | 1 | Power-down/power-up event strobe |
| sr_o | output | 16 | Current status register value |
| wr_ok_o | output | 1 | One-cycle pulse: last status write accepted |
| wr_rej_o | output | 1 | One-cycle pulse: last status write rejected |

## Verification
The suspend flag and the status write path both update the register, and they can fall on the same edge. The bench raises the suspend strobe in the same cycle as an accepted write that also moves the mode to permanent lock. It then expects bit 15 to be set together with the new mode and data bits, and the lock bits kept. A second collision, suspend with resume, must leave bit 15 clear. Enable with status write, and power cycle with enable, are provoked the same way, each judged on sr_o and the pulse outputs one edge later.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  localparam int SR_W     = 16;
  localparam int SUS_BIT  = 15;
  localparam int CMP_BIT  = 14;
  localparam int LB_LO    = 10;
  localparam int LB_N     = 4;
  localparam int SRP1_BIT = 8;
  localparam int SRP0_BIT = 7;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
  localparam int NV_LO    = WEL_BIT + 1;
  localparam int NV_HI    = CMP_BIT;

  typedef enum logic [1:0] {
    MODE_SOFT     = 2'b00,
    MODE_PIN      = 2'b01,
    MODE_LOCKDOWN = 2'b10,
    MODE_OTP      = 2'b11
  } srp_mode_e;

endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic pwr_i,
  output logic wel_o
);

  logic wel_q;
  logic wel_d;
  logic wel_en;

  always_comb begin
    wel_en = set_i | clr_i | pwr_i;
    if (pwr_i || clr_i) begin
      wel_d = 1'b0;
    end else begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  assign wel_o = wel_q;

  p_wel_drop_after_attempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wel_o);
  p_wel_set_by_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !pwr_i) |=> wel_o);

endmodule

// File: rtl/sr_write_gate.sv
module sr_write_gate
  import sr_guard_pkg::*;
(
  input  logic      attempt_i,
  input  logic      wel_i,
  input  logic      wp_n_i,
  input  srp_mode_e mode_i,
  output logic      accept_o,
  output logic      reject_o
);

  logic allowed;

  always_comb begin
    unique case (mode_i)
      MODE_SOFT:     allowed = wel_i;
      MODE_PIN:      allowed = wel_i & wp_n_i;
      MODE_LOCKDOWN: allowed = 1'b0;
      MODE_OTP:      allowed = 1'b0;
      default:       allowed = 1'b0;
    endcase
    accept_o = attempt_i & allowed;
    reject_o = attempt_i & ~allowed;
  end

endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits
  import sr_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               pwr_i,
  input  logic [NV_HI:NV_LO] wdata_i,
  output logic [NV_HI:NV_LO] nv_o,
  output srp_mode_e          mode_o
);

  logic [NV_HI:NV_LO] nv_q;
  logic [NV_HI:NV_LO] nv_d;
  logic               nv_en;
  logic [LB_N-1:0]    lb_next;
  srp_mode_e          mode_q;

  assign mode_q = srp_mode_e'(nv_q[SRP1_BIT:SRP0_BIT]);

  generate
    for (genvar g = 0; g < LB_N; g++) begin : g_lb
      assign lb_next[g] = nv_q[LB_LO+g] | wdata_i[LB_LO+g];

      p_lock_bit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_o[LB_LO+g] |=> nv_o[LB_LO+g]);
    end
  endgenerate

  always_comb begin
    nv_en = pwr_i | accept_i;
    nv_d  = nv_q;
    if (pwr_i) begin
      if (mode_q == MODE_LOCKDOWN) begin
        nv_d[SRP1_BIT:SRP0_BIT] = MODE_SOFT;
      end
    end else if (accept_i) begin
      nv_d = wdata_i;
      nv_d[LB_LO+LB_N-1:LB_LO] = lb_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= '0;
    end else if (nv_en) begin
      nv_q <= nv_d;
    end
  end

  assign nv_o   = nv_q;
  assign mode_o = mode_q;

  p_otp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_OTP) |=> $stable(nv_o));
  p_lockdown_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_i && mode_o == MODE_LOCKDOWN) |=> (mode_o == MODE_SOFT));
  p_pwr_keeps_other_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_i |=> ($stable(nv_o[CMP_BIT:LB_LO]) && $stable(nv_o[SRP0_BIT-1:NV_LO])));

endmodule

// File: rtl/sr_susp_flag.sv
module sr_susp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic pwr_i,
  output logic sus_o
);

  logic sus_q;
  logic sus_d;
  logic sus_en;

  always_comb begin
    sus_en = set_i | clr_i | pwr_i;
    sus_d  = ~(clr_i | pwr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sus_q <= 1'b0;
    end else if (sus_en) begin
      sus_q <= sus_d;
    end
  end

  assign sus_o = sus_q;

  p_resume_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !sus_o);
  p_suspend_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !pwr_i) |=> sus_o);

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import sr_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wren_i,
  input  logic            wrsr_i,
  input  logic [SR_W-1:0] wrsr_data_i,
  input  logic            susp_i,
  input  logic            resume_i,
  input  logic            wp_n_i,
  input  logic            pwr_cycle_i,
  output logic [SR_W-1:0] sr_o,
  output logic            wr_ok_o,
  output logic            wr_rej_o
);

  logic               eff_wren;
  logic               eff_wrsr;
  logic               eff_susp;
  logic               eff_resume;
  logic               wel;
  logic               sus;
  logic               accept;
  logic               reject;
  logic [NV_HI:NV_LO] nv_bits;
  srp_mode_e          mode;
  logic               ok_q;
  logic               rej_q;
  logic               ok_d;
  logic               rej_d;

  // A power cycle masks every instruction strobe of its own cycle.
  always_comb begin
    eff_wren   = wren_i   & ~pwr_cycle_i;
    eff_wrsr   = wrsr_i   & ~pwr_cycle_i;
    eff_susp   = susp_i   & ~pwr_cycle_i;
    eff_resume = resume_i & ~pwr_cycle_i;
  end

  sr_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (eff_wren),
    .clr_i (eff_wrsr),
    .pwr_i (pwr_cycle_i),
    .wel_o (wel)
  );

  sr_write_gate u_gate (
    .attempt_i (eff_wrsr),
    .wel_i     (wel),
    .wp_n_i    (wp_n_i),
    .mode_i    (mode),
    .accept_o  (accept),
    .reject_o  (reject)
  );

  sr_nv_bits u_nv (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .pwr_i    (pwr_cycle_i),
    .wdata_i  (wrsr_data_i[NV_HI:NV_LO]),
    .nv_o     (nv_bits),
    .mode_o   (mode)
  );

  sr_susp_flag u_sus (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (eff_susp),
    .clr_i (eff_resume),
    .pwr_i (pwr_cycle_i),
    .sus_o (sus)
  );

  always_comb begin
    ok_d  = accept;
    rej_d = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      rej_q <= rej_d;
    end
  end

  assign sr_o     = {sus, nv_bits, wel, 1'b0};
  assign wr_ok_o  = ok_q;
  assign wr_rej_o = rej_q;

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok_o && wr_rej_o));
  p_attempt_reports_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !pwr_cycle_i) |=> (wr_ok_o || wr_rej_o));
  p_reject_keeps_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rej_o |-> $stable(sr_o[CMP_BIT:NV_LO]));
  p_pin_low_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !pwr_cycle_i && sr_o[SRP1_BIT:SRP0_BIT] == 2'b01 && !wp_n_i) |=> wr_rej_o);
  p_lockdown_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !pwr_cycle_i && sr_o[SRP1_BIT]) |=> wr_rej_o);
  p_no_enable_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !pwr_cycle_i && !sr_o[WEL_BIT]) |=> wr_rej_o);
  p_pwr_clears_volatile_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_i |=> (!sr_o[SUS_BIT] && !sr_o[WEL_BIT] && !wr_ok_o && !wr_rej_o));
  p_sus_ignores_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && wrsr_data_i[SUS_BIT] && !sr_o[SUS_BIT] && !susp_i) |=> !sr_o[SUS_BIT]);
  p_low_bits_ignore_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && (wrsr_data_i[WEL_BIT] || wrsr_data_i[BUSY_BIT])) |=> (!sr_o[WEL_BIT] && !sr_o[BUSY_BIT]));

endmodule

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;

  logic        clk;
  logic        rst_n;
  logic        wren_i;
  logic        wrsr_i;
  logic [15:0] wrsr_data_i;
  logic        susp_i;
  logic        resume_i;
  logic        wp_n_i;
  logic        pwr_cycle_i;
  logic [15:0] sr_o;
  logic        wr_ok_o;
  logic        wr_rej_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  flash_sr_guard dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wren_i      (wren_i),
    .wrsr_i      (wrsr_i),
    .wrsr_data_i (wrsr_data_i),
    .susp_i      (susp_i),
    .resume_i    (resume_i),
    .wp_n_i      (wp_n_i),
    .pwr_cycle_i (pwr_cycle_i),
    .sr_o        (sr_o),
    .wr_ok_o     (wr_ok_o),
    .wr_rej_o    (wr_rej_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {strobes wren,wrsr,susp,resume,pwr, wp_n, data, expected sr, ok, rej}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {5'b10000, 1'b0, 16'h0000, 16'h0002, 1'b0, 1'b0},
    {5'b01000, 1'b0, 16'h0055, 16'h0054, 1'b1, 1'b0},
    {5'b01000, 1'b0, 16'h0000, 16'h0054, 1'b0, 1'b1},
    {5'b10000, 1'b0, 16'h0000, 16'h0056, 1'b0, 1'b0},
    {5'b01000, 1'b0, 16'h0480, 16'h0480, 1'b1, 1'b0},
    {5'b10000, 1'b0, 16'h0000, 16'h0482, 1'b0, 1'b0},
    {5'b01000, 1'b0, 16'h0000, 16'h0480, 1'b0, 1'b1},
    {5'b10000, 1'b1, 16'h0000, 16'h0482, 1'b0, 1'b0},
    {5'b01000, 1'b1, 16'h4880, 16'h4C80, 1'b1, 1'b0},
    {5'b00100, 1'b1, 16'h0000, 16'hCC80, 1'b0, 1'b0},
    {5'b10000, 1'b1, 16'h0000, 16'hCC82, 1'b0, 1'b0},
    {5'b01000, 1'b1, 16'h0100, 16'h8D00, 1'b1, 1'b0},
    {5'b10000, 1'b1, 16'h0000, 16'h8D02, 1'b0, 1'b0},
    {5'b01000, 1'b1, 16'h0080, 16'h8D00, 1'b0, 1'b1},
    {5'b00001, 1'b1, 16'h0000, 16'h0C00, 1'b0, 1'b0},
    {5'b11000, 1'b1, 16'h0010, 16'h0C00, 1'b0, 1'b1},
    {5'b10000, 1'b1, 16'h0000, 16'h0C02, 1'b0, 1'b0},
    {5'b01100, 1'b1, 16'h0184, 16'h8D84, 1'b1, 1'b0},
    {5'b00110, 1'b1, 16'h0000, 16'h0D84, 1'b0, 1'b0},
    {5'b10000, 1'b1, 16'h0000, 16'h0D86, 1'b0, 1'b0},
    {5'b01000, 1'b1, 16'h0000, 16'h0D84, 1'b0, 1'b1},
    {5'b10001, 1'b1, 16'h0000, 16'h0D84, 1'b0, 1'b0},
    {5'b10000, 1'b0, 16'h0000, 16'h0D86, 1'b0, 1'b0},
    {5'b01000, 1'b0, 16'hFFFF, 16'h0D84, 1'b0, 1'b1}
  };

  function automatic string req_of(input int i);
    case (i)
      1:       return "R9";
      2, 4:    return "R3";
      6, 11:   return "R4";
      8:       return "R8";
      9, 17:   return "R7";
      18:      return "R7";
      13, 14:  return "R5";
      15:      return "R12";
      20, 22:  return "R6";
      21:      return "R11";
      23:      return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wren_i = 0; wrsr_i = 0; susp_i = 0; resume_i = 0; pwr_cycle_i = 0;
    wrsr_data_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    wp_n_i = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sr after reset", sr_o, 16'h0000);
    chk("R1", "ok after reset", {15'b0, wr_ok_o}, 16'h0000);
    chk("R1", "rej after reset", {15'b0, wr_rej_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {wren_i, wrsr_i, susp_i, resume_i, pwr_cycle_i} = VEC[i][39:35];
      wp_n_i      = VEC[i][34];
      wrsr_data_i = VEC[i][33:18];
      @(negedge clk);
      chk(req_of(i), $sformatf("sr vec %0d", i), sr_o, VEC[i][17:2]);
      chk(req_of(i), $sformatf("ok vec %0d", i), {15'b0, wr_ok_o}, {15'b0, VEC[i][1]});
      chk(req_of(i), $sformatf("rej vec %0d", i), {15'b0, wr_rej_o}, {15'b0, VEC[i][0]});
      idle();
    end

    // R10: pulses last one cycle only
    @(negedge clk);
    chk("R10", "ok pulse ended", {15'b0, wr_ok_o}, 16'h0000);
    chk("R10", "rej pulse ended", {15'b0, wr_rej_o}, 16'h0000);

    // R1: asynchronous reset between edges
    #1 rst_n = 1'b0;
    #1 chk("R1", "sr async reset", sr_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: mode 00 with pin high and no enable still rejects
    wp_n_i = 1'b1;
    wrsr_i = 1'b1;
    wrsr_data_i = 16'h0020;
    @(negedge clk);
    idle();
    chk("R3", "sr no enable", sr_o, 16'h0000);
    chk("R3", "rej no enable", {15'b0, wr_rej_o}, 16'h0001);

    // R3: mode 00 with pin low and enable accepts
    wp_n_i = 1'b0;
    wren_i = 1'b1;
    @(negedge clk);
    idle();
    wrsr_i = 1'b1;
    wrsr_data_i = 16'h4020;
    @(negedge clk);
    idle();
    chk("R3", "sr pin low soft mode", sr_o, 16'h4020);
    chk("R3", "ok pin low soft mode", {15'b0, wr_ok_o}, 16'h0001);

    // R7: resume alone clears suspend
    susp_i = 1'b1;
    @(negedge clk);
    idle();
    chk("R7", "sus set", sr_o, 16'hC020);
    resume_i = 1'b1;
    @(negedge clk);
    idle();
    chk("R7", "sus cleared", sr_o, 16'h4020);

    finish_run();
  end

endmodule